// File: doc/BRIEF.md
# Overwriting Dual-Clock Circular Sample Buffer

This block is a circular sample store for a video stream. Samples come in on one clock and go out on another. The two clocks need not share a frequency or a phase. Writes are never refused. Once the store has wrapped, new samples replace the oldest ones. The read side has two behaviours, chosen by what has happened since reset:

- **Halting:** the read address stops advancing when it catches up with the write address. The output then keeps showing the last sample read.
- **Released:** a pointer command issued while `load_en` is high leaves the halting behaviour for good. From then on reads always advance, and the flags are marked as no longer trustworthy.

Each pointer can be cleared to address 0 or jumped to any address, on its own clock. The read side reports three flags: a collide flag (addresses equal), an almost-empty flag and an almost-full flag. The two thresholds are given in eightieths of the store depth, and all distances are taken modulo the address space. The write address crosses into the read clock domain as Gray code through two flip-flop stages.

Top module: `vbuf_ring_fifo`

## Requirements
- R1: With no commands issued, words come out on `rd_data` in the order they were written. `rd_data` is updated on the `rd_clk` edge where `rd_en` is high.
- R2: `wr_en` is never refused. After DEPTH+m writes with no reads, the write address has wrapped to m. A reader still at address 0 then gets the last m words written.
- R3: In halting behaviour, a read request when the read address equals the synchronised write address leaves the read address and `rd_data` unchanged. The output keeps the last sample read until new data arrives.
- R4: `collide` is high when the read address equals the synchronised write address. It is registered in the read domain.
- R5: `almost_empty` is high when fill < floor(DEPTH*k/80). Here fill = (write address - read address) mod DEPTH, and k is `ae_thresh` (7 bits, 1 to 79).
- R6: `almost_full` is high when free = (read address - write address) mod DEPTH is less than floor(DEPTH*k/80), with k taken from `af_thresh`. When the addresses are equal, free is 0, so both flags are high.
- R7: After a synchronous reset both addresses are 0, `rd_data` is 0, and `collide`, `almost_empty`, `almost_full` and `flags_valid` are all 1.
- R8: A clear or jump on either side while `load_en` is 1 drops `flags_valid` to 0, which stays low until reset. From then on, reads advance even when the addresses are equal. With `load_en` at 0, commands leave `flags_valid` at 1.
- R9: A clear forces that pointer to 0 on the next edge of its own clock. It takes priority over a jump, and no read or write is done in that cycle.
- R10: A jump forces that pointer to its jump address input on the next edge of its own clock. No read or write is done in that cycle.
- R11: The registered Gray copy of the write address changes by at most one bit per write clock, except after a clear or a jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Store `wr_data` and advance the write address |
| wr_data | input | DATA_W | Sample to store |
| wr_clear | input | 1 | Force the write address to 0 |
| wr_jump | input | 1 | Force the write address to `wr_jump_addr` |
| wr_jump_addr | input | ADDR_W | Jump target for the write address |
| rd_clk | input | 1 | Read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Request the next sample |
| rd_clear | input | 1 | Force the read address to 0 |
| rd_jump | input | 1 | Force the read address to `rd_jump_addr` |
| rd_jump_addr | input | ADDR_W | Jump target for the read address |
| load_en | input | 1 | When high, pointer commands release the halting behaviour (quasi-static) |
| ae_thresh | input | 7 | Almost-empty threshold in eightieths of the depth |
| af_thresh | input | 7 | Almost-full threshold in eightieths of the depth |
| rd_data | output | DATA_W | Registered read sample |
| collide | output | 1 | Read address equals write address |
| almost_empty | output | 1 | Fill below the almost-empty threshold |
| almost_full | output | 1 | Free space below the almost-full threshold |
| flags_valid | output | 1 | Low once the halting behaviour has been released |

## Verification
The flags are tried with write counts placed just below, exactly on, and just above each threshold word count. These counts separate a strict compare from an inclusive one and show that the floor is taken. Counts of exactly DEPTH and beyond DEPTH show the wrap of the modulo distance, and with it the case where both flags are high at equality. Data-order runs with distinct sample values show three things apart: plain ordering, overwrite of the oldest words, and the held output when empty. Pointer commands are tried once with `load_en` low and once with it high. This tells a jump that keeps the halting behaviour from a command that releases it, where reads then run past the write address.

// File: rtl/vbuf_pkg.sv
package vbuf_pkg;
  localparam int THRESH_W   = 7;
  localparam int THRESH_DEN = 80;

  typedef struct packed {
    logic collide;
    logic near_empty;
    logic near_full;
    logic valid;
  } vbuf_flags_t;
endpackage

// File: rtl/vbuf_sync.sv
module vbuf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/vbuf_ptr.sv
module vbuf_ptr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              jump,
  input  logic [ADDR_W-1:0] jump_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst || clear) ptr <= '0;
    else if (jump)    ptr <= jump_addr;
    else if (step)    ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/vbuf_dpram.sv
module vbuf_dpram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              wr_clk,
  input  logic              wr_we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_re,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_we) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)     rd_q <= '0;
    else if (rd_re) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/vbuf_ring_fifo.sv
module vbuf_ring_fifo
  import vbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic                wr_clk,
  input  logic                wr_rst,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                wr_clear,
  input  logic                wr_jump,
  input  logic [ADDR_W-1:0]   wr_jump_addr,
  input  logic                rd_clk,
  input  logic                rd_rst,
  input  logic                rd_en,
  input  logic                rd_clear,
  input  logic                rd_jump,
  input  logic [ADDR_W-1:0]   rd_jump_addr,
  input  logic                load_en,
  input  logic [THRESH_W-1:0] ae_thresh,
  input  logic [THRESH_W-1:0] af_thresh,
  output logic [DATA_W-1:0]   rd_data,
  output logic                collide,
  output logic                almost_empty,
  output logic                almost_full,
  output logic                flags_valid
);
  localparam int PW = ADDR_W + THRESH_W + 1;

  function automatic logic [ADDR_W-1:0] to_gray(input logic [ADDR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [ADDR_W-1:0] from_gray(input logic [ADDR_W-1:0] g);
    logic [ADDR_W-1:0] b;
    b[ADDR_W-1] = g[ADDR_W-1];
    for (int i = ADDR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  logic [ADDR_W-1:0] wptr, wgray;
  logic              wr_step, free_run_w;

  assign wr_step = wr_en & ~wr_clear & ~wr_jump;

  vbuf_ptr #(.ADDR_W(ADDR_W)) u_wptr (
    .clk(wr_clk), .rst(wr_rst), .clear(wr_clear), .jump(wr_jump),
    .jump_addr(wr_jump_addr), .step(wr_step), .ptr(wptr)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wgray      <= '0;
      free_run_w <= 1'b0;
    end else begin
      wgray <= to_gray(wptr);
      if (load_en && (wr_clear || wr_jump)) free_run_w <= 1'b1;
    end
  end

  // crossing
  logic [ADDR_W:0]   xing_q;
  logic [ADDR_W-1:0] wbin_rd;
  logic              free_w_sync;

  vbuf_sync #(.W(ADDR_W + 1), .STAGES(2)) u_sync (
    .clk(rd_clk), .rst(rd_rst), .d({free_run_w, wgray}), .q(xing_q)
  );

  assign free_w_sync = xing_q[ADDR_W];
  assign wbin_rd     = from_gray(xing_q[ADDR_W-1:0]);

  // read domain
  logic [ADDR_W-1:0] rptr, fill, room;
  logic              rd_step, free_run_rd;
  logic [PW-1:0]     ae_lim, af_lim;
  vbuf_flags_t       flags_q;

  assign fill    = wbin_rd - rptr;
  assign room    = rptr - wbin_rd;
  assign rd_step = rd_en & ~rd_clear & ~rd_jump & (free_run_rd | (fill != '0));

  // threshold words = floor(2^ADDR_W * k / 80)
  assign ae_lim = (PW'(ae_thresh) << ADDR_W) / PW'(THRESH_DEN);
  assign af_lim = (PW'(af_thresh) << ADDR_W) / PW'(THRESH_DEN);

  vbuf_ptr #(.ADDR_W(ADDR_W)) u_rptr (
    .clk(rd_clk), .rst(rd_rst), .clear(rd_clear), .jump(rd_jump),
    .jump_addr(rd_jump_addr), .step(rd_step), .ptr(rptr)
  );

  vbuf_dpram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk(wr_clk), .wr_we(wr_step), .wr_addr(wptr), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_re(rd_step), .rd_addr(rptr),
    .rd_q(rd_data)
  );

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      free_run_rd <= 1'b0;
      flags_q     <= '{collide: 1'b1, near_empty: 1'b1, near_full: 1'b1, valid: 1'b1};
    end else begin
      if (free_w_sync || (load_en && (rd_clear || rd_jump))) free_run_rd <= 1'b1;
      flags_q.collide    <= (rptr == wbin_rd);
      flags_q.near_empty <= (PW'(fill) < ae_lim);
      flags_q.near_full  <= (PW'(room) < af_lim);
      flags_q.valid      <= ~free_run_rd;
    end
  end

  assign collide      = flags_q.collide;
  assign almost_empty = flags_q.near_empty;
  assign almost_full  = flags_q.near_full;
  assign flags_valid  = flags_q.valid;
endmodule

// File: rtl/vbuf_ring_fifo_chk.sv
module vbuf_ring_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input logic              wr_clk,
  input logic              wr_rst,
  input logic              wr_clear,
  input logic              wr_jump,
  input logic [ADDR_W-1:0] wr_jump_addr,
  input logic [ADDR_W-1:0] wptr,
  input logic [ADDR_W-1:0] wgray,
  input logic              rd_clk,
  input logic              rd_rst,
  input logic              rd_en,
  input logic              rd_clear,
  input logic              rd_jump,
  input logic [ADDR_W-1:0] rd_jump_addr,
  input logic [ADDR_W-1:0] rptr,
  input logic [ADDR_W-1:0] wbin_rd,
  input logic              free_run_rd,
  input logic [DATA_W-1:0] rd_data,
  input logic              collide,
  input logic              flags_valid
);
  p_hold_empty_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_en && !rd_clear && !rd_jump && !free_run_rd && rptr == wbin_rd)
      |=> ($stable(rd_data) && $stable(rptr)));

  p_collide_eq_r4: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rptr == wbin_rd) |=> collide);

  p_valid_sticky_r8: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !flags_valid |=> !flags_valid);

  p_rd_clear_r9: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_clear |=> (rptr == '0));

  p_wr_clear_r9: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_clear |=> (wptr == '0));

  p_rd_jump_r10: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_jump && !rd_clear) |=> (rptr == $past(rd_jump_addr)));

  p_wr_jump_r10: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_jump && !wr_clear) |=> (wptr == $past(wr_jump_addr)));

  p_gray_step_r11: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (!wr_clear && !wr_jump && !$past(wr_clear) && !$past(wr_jump))
      |=> ($countones(wgray ^ $past(wgray)) <= 1));
endmodule

bind vbuf_ring_fifo vbuf_ring_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_vbuf_ring_fifo.sv
`timescale 1ns/1ps
module sim_vbuf_ring_fifo;
  localparam int DW = 8;
  localparam int AW = 6;

  logic          wr_clk = 0, rd_clk = 0;
  logic          wr_rst, rd_rst, wr_en, wr_clear, wr_jump;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] wr_jump_addr, rd_jump_addr;
  logic          rd_en, rd_clear, rd_jump, load_en;
  logic [6:0]    ae_thresh, af_thresh;
  logic [DW-1:0] rd_data;
  logic          collide, almost_empty, almost_full, flags_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4   wr_clk = ~wr_clk;  // 125 MHz
  always #5.5 rd_clk = ~rd_clk;

  vbuf_ring_fifo #(.DATA_W(DW), .ADDR_W(AW)) u0 (.*);

  // per row: writes, ae_k, af_k, exp_ae, exp_af, exp_collide (depth 64)
  localparam int TBL [8][6] = '{
    '{ 5, 10, 70, 1, 0, 0},
    '{ 8, 10, 70, 0, 0, 0},
    '{ 7, 10, 70, 1, 0, 0},
    '{60, 10,  5, 0, 0, 0},
    '{61, 10,  5, 0, 1, 0},
    '{64, 10,  5, 1, 1, 1},
    '{70, 10, 79, 1, 1, 0},
    '{ 1,  1,  1, 0, 0, 0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_rst = 1; rd_rst = 1;
    wr_en = 0; wr_clear = 0; wr_jump = 0; wr_data = '0; wr_jump_addr = '0;
    rd_en = 0; rd_clear = 0; rd_jump = 0; rd_jump_addr = '0;
    repeat (4) @(negedge rd_clk);
    wr_rst = 0; rd_rst = 0;
    repeat (2) @(negedge rd_clk);
  endtask

  task automatic burst(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en = 1; wr_data = DW'(base + i);
    end
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic read_one(output logic [DW-1:0] d);
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
    d = rd_data;
  endtask

  task automatic rd_cmd(input bit clr, input bit jmp, input logic [AW-1:0] a);
    @(negedge rd_clk); rd_clear = clr; rd_jump = jmp; rd_jump_addr = a;
    @(negedge rd_clk); rd_clear = 0; rd_jump = 0;
  endtask

  task automatic wr_cmd(input bit clr, input bit jmp, input logic [AW-1:0] a);
    @(negedge wr_clk); wr_clear = clr; wr_jump = jmp; wr_jump_addr = a;
    @(negedge wr_clk); wr_clear = 0; wr_jump = 0;
  endtask

  initial begin
    logic [DW-1:0] d;
    load_en = 0; ae_thresh = 7'd10; af_thresh = 7'd70;
    do_reset();

    // R7 reset state
    check(rd_data == 0,     "R7 rd_data",      rd_data, 0);
    check(collide == 1,     "R7 collide",      collide, 1);
    check(almost_empty == 1, "R7 almost_empty", almost_empty, 1);
    check(almost_full == 1, "R7 almost_full",  almost_full, 1);
    check(flags_valid == 1, "R7 flags_valid",  flags_valid, 1);

    // R4 R5 R6 threshold table
    for (int t = 0; t < 8; t++) begin
      ae_thresh = 7'(TBL[t][1]); af_thresh = 7'(TBL[t][2]);
      do_reset();
      burst(TBL[t][0], 0);
      settle();
      check(almost_empty == TBL[t][3], $sformatf("R5 row %0d", t), almost_empty, TBL[t][3]);
      check(almost_full  == TBL[t][4], $sformatf("R6 row %0d", t), almost_full,  TBL[t][4]);
      check(collide      == TBL[t][5], $sformatf("R4 row %0d", t), collide,      TBL[t][5]);
    end

    // R1 ordering, R3 hold when empty
    ae_thresh = 7'd10; af_thresh = 7'd70;
    do_reset();
    burst(4, 8'h10);
    settle();
    for (int i = 0; i < 4; i++) begin
      read_one(d);
      check(d == 8'(8'h10 + i), "R1 order", d, 8'h10 + i);
    end
    read_one(d);
    check(d == 8'h13, "R3 held when empty", d, 8'h13);
    settle();
    check(collide == 1, "R4 collide after drain", collide, 1);

    // R8 release with load_en high
    load_en = 1;
    wr_cmd(1, 0, '0);
    settle();
    check(flags_valid == 0, "R8 flags_valid low", flags_valid, 0);
    rd_cmd(1, 0, '0);
    read_one(d);
    check(d == 8'h10, "R8 R9 read past write addr", d, 8'h10);
    read_one(d);
    check(d == 8'h11, "R8 second free read", d, 8'h11);
    settle();
    check(flags_valid == 0, "R8 stays low", flags_valid, 0);

    // R2 overwrite, then R3 hold and refill
    load_en = 0;
    do_reset();
    burst(70, 0);
    settle();
    for (int i = 0; i < 6; i++) begin
      read_one(d);
      check(d == 8'(64 + i), "R2 newest words", d, 64 + i);
    end
    read_one(d);
    check(d == 8'd69, "R3 repeat last", d, 69);
    read_one(d);
    check(d == 8'd69, "R3 repeat again", d, 69);
    burst(1, 8'h55);
    settle();
    read_one(d);
    check(d == 8'h55, "R3 resume after write", d, 8'h55);

    // R10 jumps with load_en low (no release)
    do_reset();
    burst(8, 8'h20);
    settle();
    rd_cmd(0, 1, 6'd5);
    read_one(d);
    check(d == 8'h25, "R10 read jump", d, 8'h25);
    wr_cmd(0, 1, 6'd40);
    burst(1, 8'hE1);
    settle();
    rd_cmd(0, 1, 6'd40);
    read_one(d);
    check(d == 8'hE1, "R10 write jump", d, 8'hE1);
    check(flags_valid == 1, "R8 no release when load_en low", flags_valid, 1);
    read_one(d);
    check(d == 8'hE1, "R3 hold after jump", d, 8'hE1);

    // R9 clear wins over jump
    burst(3, 8'h60);
    settle();
    rd_cmd(1, 1, 6'd41);
    read_one(d);
    check(d == 8'h20, "R9 clear priority", d, 8'h20);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule